// File: doc/BRIEF.md
# Bypass Mode Arbiter

This block sits between the strobe pins of two ports that share a FIFO and decides what a falling bypass strobe means. A bypass strobe pulled low on its own opens a decision window a fixed number of clock cycles long. When the window closes with the port's FIFO strobe still high, the block issues a one-cycle start pulse for a registered mailbox access. When the FIFO strobe falls inside the window, no earlier than a setup distance after the bypass strobe, the block instead enters transparent mode, in which data from the starting port is passed straight to the opposite port. A FIFO strobe that falls too soon after the bypass strobe is rejected, so no pass-through, no mailbox start and no FIFO access come of it.

The block drives the two port output enables. In normal operation, a registered direction input picks which port drives. During a pass-through, the sending port is released and the receiving port is enabled after a fixed latency. Whenever the two ports' strobes conflict, both ports are released. An external data mux uses the transparent indication and its direction as its select. A per-port qualifier tells the FIFO when that port's FIFO strobe may act on the FIFO. All analog delays are modelled as clock-cycle counts: SETUP_CYC, WINDOW_CYC and PASS_LAT_CYC.

Top module: `bypass_mode_arbiter`

## Requirements
- R1: After synchronous reset, reg_start_a, reg_start_b, xp_active and conflict are 0, and oe_a equals fifo_b_to_a while oe_b is its inverse.
- R2: Take the clock edge that first samples byp_a_n low with stb_a_n high as edge 0. If stb_a_n is not sampled low before edge WINDOW_CYC, reg_start_a is 1 for exactly the one cycle after edge WINDOW_CYC, once per fall.
- R3: If stb_a_n is sampled low at edge k with k < SETUP_CYC (k = 0 meaning together with the bypass fall), the attempt is rejected: no start pulse and no transparent mode until byp_a_n returns high.
- R4: If stb_a_n is sampled low at edge k with SETUP_CYC <= k < WINDOW_CYC, no start pulse is issued and xp_active rises after edge k+1 with xp_dir = 0 (0 = port A sends to port B, 1 = port B sends to port A).
- R5: Port B follows R2, R3, R4 and R7 with its own strobes, its own start pulse and xp_dir = 1.
- R6: During a pass-through the sending port's enable is 0. The receiving port's enable is 0 when xp_active rises and becomes 1 exactly PASS_LAT_CYC cycles later.
- R7: When either strobe of the starting port is sampled high at edge r, xp_active is still 1 after edge r and is 0 after edge r+1, with the enables back to their normal values.
- R8: If both ports reach the transparent condition together, conflict rises, xp_active stays 0 and both enables are 0. This holds until an edge samples all four strobes high, after which conflict is 0.
- R9: While a pass-through is active, any low strobe on the other port moves the block into the conflict state of R8.
- R10: A FIFO strobe first sampled low at or after edge WINDOW_CYC does not cancel the start pulse of R2.
- R11: fifo_qual_x is 0 while port x's decision window is open, after a rejected attempt until the bypass strobe rises, and for both ports during a pass-through or a conflict. It is 1 when the block is idle or after a start pulse has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_b_to_a | input | 1 | FIFO direction; 1 makes port A the normal driver |
| byp_a_n | input | 1 | Port A bypass strobe, active low |
| stb_a_n | input | 1 | Port A FIFO strobe, active low |
| byp_b_n | input | 1 | Port B bypass strobe, active low |
| stb_b_n | input | 1 | Port B FIFO strobe, active low |
| reg_start_a | output | 1 | One-cycle registered mailbox start from port A |
| reg_start_b | output | 1 | One-cycle registered mailbox start from port B |
| xp_active | output | 1 | Transparent pass-through in progress |
| xp_dir | output | 1 | Pass-through direction / data mux select (1 = B to A) |
| conflict | output | 1 | Strobe conflict, both ports released |
| oe_a | output | 1 | Port A output enable |
| oe_b | output | 1 | Port B output enable |
| fifo_qual_a | output | 1 | Port A FIFO strobe may act on the FIFO |
| fifo_qual_b | output | 1 | Port B FIFO strobe may act on the FIFO |

## Verification
A per-port window counter that is off by one moves the start pulse, or the transparent/rejected boundary, by exactly one cycle. This shows at reg_start_x or xp_active within WINDOW_CYC+2 cycles of the bypass fall. A mode register left in the wrong state keeps an enable driven or released, which is seen on oe_a/oe_b one cycle after the strobe edge that should have changed it. A latency counter that is wrong moves the receiver's enable edge away from PASS_LAT_CYC. The bench sweeps the FIFO strobe delay across every region on both ports and compares each sampled cycle.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [2:0] {
    TRK_IDLE,
    TRK_WIN,
    TRK_WAIT,
    TRK_XREQ,
    TRK_DONE
  } trk_state_t;

  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_XA,
    ARB_XB,
    ARB_CONF
  } arb_state_t;
endpackage

// File: rtl/bma_port_tracker.sv
module bma_port_tracker #(
  parameter int SETUP_CYC  = 2,
  parameter int WINDOW_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic byp_n,
  input  logic stb_n,
  output logic xreq,
  output logic start_pulse,
  output logic quiet
);
  import bma_pkg::*;

  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] SETUP_V = CW'(SETUP_CYC);
  localparam logic [CW-1:0] WIN_V   = CW'(WINDOW_CYC);

  trk_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= TRK_IDLE;
      cnt         <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      case (st)
        TRK_IDLE: begin
          if (!byp_n) begin
            if (!stb_n) begin
              st <= TRK_WAIT;
            end else begin
              st  <= TRK_WIN;
              cnt <= CW'(1);
            end
          end
        end
        TRK_WIN: begin
          if (byp_n) begin
            st <= TRK_IDLE;
          end else if (!stb_n && cnt < WIN_V) begin
            st <= (cnt < SETUP_V) ? TRK_WAIT : TRK_XREQ;
          end else if (cnt == WIN_V) begin
            st          <= TRK_DONE;
            start_pulse <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        TRK_WAIT: if (byp_n) st <= TRK_IDLE;
        TRK_XREQ: begin
          if (byp_n)      st <= TRK_IDLE;
          else if (stb_n) st <= TRK_WAIT;
        end
        TRK_DONE: if (byp_n) st <= TRK_IDLE;
        default:  st <= TRK_IDLE;
      endcase
    end
  end

  assign xreq  = (st == TRK_XREQ);
  assign quiet = (st == TRK_IDLE) || (st == TRK_DONE);
endmodule

// File: rtl/bma_lat_timer.sv
module bma_lat_timer #(
  parameter int PASS_LAT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic ready
);
  localparam int LW = $clog2(PASS_LAT_CYC + 1);
  localparam logic [LW-1:0] LAT_V = LW'(PASS_LAT_CYC);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt   <= cnt + LW'(1);
      ready <= (cnt + LW'(1)) >= LAT_V;
    end
  end
endmodule

// File: rtl/bma_mode_fsm.sv
module bma_mode_fsm #(
  parameter int PASS_LAT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_b_to_a,
  input  logic xreq_a,
  input  logic xreq_b,
  input  logic busy_a,
  input  logic busy_b,
  output logic xp_active,
  output logic xp_dir,
  output logic conflict,
  output logic oe_a,
  output logic oe_b,
  output logic idle
);
  import bma_pkg::*;

  arb_state_t st, nxt;
  logic dir_q;
  logic ready;

  always_comb begin
    nxt = st;
    case (st)
      ARB_IDLE: begin
        if (xreq_a && xreq_b) nxt = ARB_CONF;
        else if (xreq_a)      nxt = ARB_XA;
        else if (xreq_b)      nxt = ARB_XB;
      end
      ARB_XA: begin
        if (busy_b)       nxt = ARB_CONF;
        else if (!xreq_a) nxt = ARB_IDLE;
      end
      ARB_XB: begin
        if (busy_a)       nxt = ARB_CONF;
        else if (!xreq_b) nxt = ARB_IDLE;
      end
      ARB_CONF: if (!busy_a && !busy_b) nxt = ARB_IDLE;
      default:  nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ARB_IDLE;
      dir_q <= fifo_b_to_a;
    end else begin
      st    <= nxt;
      dir_q <= fifo_b_to_a;
    end
  end

  bma_lat_timer #(.PASS_LAT_CYC(PASS_LAT_CYC)) lat_i (
    .clk   (clk),
    .rst   (rst),
    .run   ((st == ARB_XA) || (st == ARB_XB)),
    .ready (ready)
  );

  always_comb begin
    case (st)
      ARB_XA:   begin oe_a = 1'b0;  oe_b = ready;  end
      ARB_XB:   begin oe_a = ready; oe_b = 1'b0;   end
      ARB_CONF: begin oe_a = 1'b0;  oe_b = 1'b0;   end
      default:  begin oe_a = dir_q; oe_b = !dir_q; end
    endcase
  end

  assign xp_active = (st == ARB_XA) || (st == ARB_XB);
  assign xp_dir    = (st == ARB_XB);
  assign conflict  = (st == ARB_CONF);
  assign idle      = (st == ARB_IDLE);
endmodule

// File: rtl/bypass_mode_arbiter.sv
module bypass_mode_arbiter #(
  parameter int SETUP_CYC    = 2,
  parameter int WINDOW_CYC   = 5,
  parameter int PASS_LAT_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_b_to_a,
  input  logic byp_a_n,
  input  logic stb_a_n,
  input  logic byp_b_n,
  input  logic stb_b_n,
  output logic reg_start_a,
  output logic reg_start_b,
  output logic xp_active,
  output logic xp_dir,
  output logic conflict,
  output logic oe_a,
  output logic oe_b,
  output logic fifo_qual_a,
  output logic fifo_qual_b
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] byp_v, stb_v, xreq_v, start_v, quiet_v, busy_v;
  logic arb_idle;

  assign byp_v = {byp_b_n, byp_a_n};
  assign stb_v = {stb_b_n, stb_a_n};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    bma_port_tracker #(
      .SETUP_CYC  (SETUP_CYC),
      .WINDOW_CYC (WINDOW_CYC)
    ) trk_i (
      .clk         (clk),
      .rst         (rst),
      .byp_n       (byp_v[p]),
      .stb_n       (stb_v[p]),
      .xreq        (xreq_v[p]),
      .start_pulse (start_v[p]),
      .quiet       (quiet_v[p])
    );
    assign busy_v[p] = !byp_v[p] || !stb_v[p];
  end

  bma_mode_fsm #(.PASS_LAT_CYC(PASS_LAT_CYC)) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .fifo_b_to_a (fifo_b_to_a),
    .xreq_a      (xreq_v[0]),
    .xreq_b      (xreq_v[1]),
    .busy_a      (busy_v[0]),
    .busy_b      (busy_v[1]),
    .xp_active   (xp_active),
    .xp_dir      (xp_dir),
    .conflict    (conflict),
    .oe_a        (oe_a),
    .oe_b        (oe_b),
    .idle        (arb_idle)
  );

  assign reg_start_a = start_v[0];
  assign reg_start_b = start_v[1];
  assign fifo_qual_a = quiet_v[0] && arb_idle;
  assign fifo_qual_b = quiet_v[1] && arb_idle;
endmodule

// File: rtl/bma_checks.sv
module bma_checks (
  input logic clk,
  input logic rst,
  input logic byp_a_n,
  input logic byp_b_n,
  input logic reg_start_a,
  input logic reg_start_b,
  input logic xp_active,
  input logic xp_dir,
  input logic conflict,
  input logic oe_a,
  input logic oe_b,
  input logic fifo_qual_a,
  input logic fifo_qual_b
);
  AST_START_A_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_start_a |=> !reg_start_a); // R2
  AST_START_A_BYP: assert property (@(posedge clk) disable iff (rst) reg_start_a |-> $past(!byp_a_n)); // R2
  AST_START_B_SINGLE: assert property (@(posedge clk) disable iff (rst) reg_start_b |=> !reg_start_b); // R5
  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(oe_a && oe_b)); // R6
  AST_XP_SENDER_OFF: assert property (@(posedge clk) disable iff (rst) (xp_active && !xp_dir) |-> !oe_a); // R6
  AST_XP_RISE_DARK: assert property (@(posedge clk) disable iff (rst) $rose(xp_active) |-> (!oe_a && !oe_b)); // R6
  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (rst) conflict |-> (!oe_a && !oe_b && !xp_active)); // R8
  AST_XP_NO_FIFO: assert property (@(posedge clk) disable iff (rst) xp_active |-> (!fifo_qual_a && !fifo_qual_b)); // R11
  AST_B_START_IN_XP: assert property (@(posedge clk) disable iff (rst) (reg_start_b && !byp_b_n) |-> !(xp_active && xp_dir)); // R5
endmodule

bind bypass_mode_arbiter bma_checks chk_i (
  .clk         (clk),
  .rst         (rst),
  .byp_a_n     (byp_a_n),
  .byp_b_n     (byp_b_n),
  .reg_start_a (reg_start_a),
  .reg_start_b (reg_start_b),
  .xp_active   (xp_active),
  .xp_dir      (xp_dir),
  .conflict    (conflict),
  .oe_a        (oe_a),
  .oe_b        (oe_b),
  .fifo_qual_a (fifo_qual_a),
  .fifo_qual_b (fifo_qual_b)
);

// File: tb/bypass_mode_arbiter_tb_top.sv
module bypass_mode_arbiter_tb_top;
  localparam int TBS = 2;
  localparam int DLY = 5;
  localparam int LAT = 3;
  localparam int NEVER = 99;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b0;
  logic bn [2];
  logic sn [2];
  logic reg_start_a, reg_start_b, xp_active, xp_dir, conflict;
  logic oe_a, oe_b, fifo_qual_a, fifo_qual_b;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bypass_mode_arbiter #(
    .SETUP_CYC(TBS), .WINDOW_CYC(DLY), .PASS_LAT_CYC(LAT)
  ) dut_i (
    .clk(clk), .rst(rst), .fifo_b_to_a(dir),
    .byp_a_n(bn[0]), .stb_a_n(sn[0]), .byp_b_n(bn[1]), .stb_b_n(sn[1]),
    .reg_start_a(reg_start_a), .reg_start_b(reg_start_b),
    .xp_active(xp_active), .xp_dir(xp_dir), .conflict(conflict),
    .oe_a(oe_a), .oe_b(oe_b), .fifo_qual_a(fifo_qual_a), .fifo_qual_b(fifo_qual_b)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // 0 rejected, 1 pass-through, 2 registered start
  function automatic int outcome(input int c);
    if (c < TBS) return 0;
    if (c < DLY) return 1;
    return 2;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // port p drops its bypass strobe at index 0, FIFO strobe at index c, releases both at rel
  task automatic trial(input int p, input int c, input int rel);
    int kind;
    string tag;
    logic e_st, e_xp, e_oea, e_oeb, e_qown, e_qoth, a_st, a_sto, a_qown, a_qoth;
    kind = outcome(c);
    for (int j = 0; j < rel + 4; j++) begin
      bn[p] = (j < rel) ? 1'b0 : 1'b1;
      sn[p] = (j >= c && j < rel) ? 1'b0 : 1'b1;
      @(negedge clk);
      e_st = (kind == 2) && (j == DLY);
      e_xp = (kind == 1) && (j >= c + 1) && (j <= rel);
      e_oea = dir;
      e_oeb = !dir;
      if (e_xp) begin
        e_oea = (p == 1) ? (j >= c + 1 + LAT) : 1'b0;
        e_oeb = (p == 0) ? (j >= c + 1 + LAT) : 1'b0;
      end
      case (kind)
        0: e_qown = (j >= rel);
        1: e_qown = (j > rel);
        default: e_qown = (j >= DLY);
      endcase
      e_qoth = !e_xp;
      a_st   = (p == 0) ? reg_start_a : reg_start_b;
      a_sto  = (p == 0) ? reg_start_b : reg_start_a;
      a_qown = (p == 0) ? fifo_qual_a : fifo_qual_b;
      a_qoth = (p == 0) ? fifo_qual_b : fifo_qual_a;
      if (p == 1) tag = "R5";
      else if (kind == 0) tag = "R3";
      else if (kind == 1) tag = "R4";
      else tag = (c == NEVER) ? "R2" : "R10";
      chk(tag, "start pulse", a_st, e_st);
      chk(tag, "other start", a_sto, 1'b0);
      chk((j > rel) ? "R7" : tag, "xp_active", xp_active, e_xp);
      if (e_xp) chk(tag, "xp_dir", xp_dir, logic'(p));
      chk("R6", "oe_a", oe_a, e_oea);
      chk("R6", "oe_b", oe_b, e_oeb);
      chk("R11", "own qual", a_qown, e_qown);
      chk("R11", "other qual", a_qoth, e_qoth);
      chk("R8", "no conflict", conflict, 1'b0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    report();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h0BAD5EED);
    bn[0] = 1'b1; sn[0] = 1'b1; bn[1] = 1'b1; sn[1] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reg_start_a", reg_start_a, 1'b0);
    chk("R1", "reg_start_b", reg_start_b, 1'b0);
    chk("R1", "xp_active", xp_active, 1'b0);
    chk("R1", "conflict", conflict, 1'b0);
    chk("R1", "oe_a", oe_a, 1'b0);
    chk("R1", "oe_b", oe_b, 1'b1);
    dir = 1'b1;
    @(negedge clk);
    chk("R1", "oe_a dir1", oe_a, 1'b1);
    chk("R1", "oe_b dir1", oe_b, 1'b0);
    dir = 1'b0;
    @(negedge clk);

    // directed corners on both ports
    for (int p = 0; p < 2; p++) begin
      trial(p, 0, 4);              // R3 together
      trial(p, TBS - 1, 4);        // R3 just early
      trial(p, TBS, 9);            // R4 first legal
      trial(p, DLY - 1, 10);       // R4 last legal
      trial(p, DLY, DLY + 3);      // R10
      trial(p, NEVER, DLY + 2);    // R2
    end

    // R8 both ports reach transparent together
    bn[0] = 0; bn[1] = 0;
    repeat (2) @(negedge clk);
    sn[0] = 0; sn[1] = 0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    chk("R8", "conflict", conflict, 1'b1);
    chk("R8", "xp_active", xp_active, 1'b0);
    chk("R8", "oe_a", oe_a, 1'b0);
    chk("R8", "oe_b", oe_b, 1'b0);
    repeat (2) @(negedge clk);
    bn[0] = 1; sn[0] = 1;
    @(negedge clk);
    chk("R8", "held by B", conflict, 1'b1);
    bn[1] = 1; sn[1] = 1;
    @(negedge clk);
    chk("R8", "cleared", conflict, 1'b0);
    chk("R8", "oe_b back", oe_b, 1'b1);
    chk("R8", "no start a", reg_start_a, 1'b0);
    repeat (2) @(negedge clk);

    // R9 other port strobe during pass-through
    bn[0] = 0;
    repeat (2) @(negedge clk);
    sn[0] = 0;
    repeat (2) @(negedge clk);
    chk("R9", "xp up", xp_active, 1'b1);
    @(negedge clk);
    bn[1] = 0;
    @(negedge clk);
    chk("R9", "conflict", conflict, 1'b1);
    chk("R9", "oe_b", oe_b, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9", "no start b", reg_start_b, 1'b0);
    end
    bn[1] = 1;
    repeat (2) @(negedge clk);
    chk("R9", "held by A", conflict, 1'b1);
    bn[0] = 1; sn[0] = 1;
    @(negedge clk);
    chk("R9", "cleared", conflict, 1'b0);
    repeat (2) @(negedge clk);

    // constrained random sweep
    for (int t = 0; t < 80; t++) begin
      int p, c, rel;
      p = int'($urandom_range(0, 1));
      c = int'($urandom_range(0, DLY + 2));
      if (c == DLY + 2) c = NEVER;
      rel = max2((c == NEVER) ? DLY : c, DLY) + 1 + int'($urandom_range(0, 4));
      if (outcome(c) != 2) rel = c + 1 + int'($urandom_range(0, 6));
      dir = 1'b0;
      trial(p, c, rel);
    end
    report();
  end
endmodule